// File: doc/BRIEF.md
# Serial Output Freeze Controller

This block lets a host stop and restart a set of free-running clock outputs through a two-wire serial link. The host sends a frame on a data line, timed by its own serial clock: a low start bit, then one enable bit for every gated output. A bit of 0 stops its output at logic 0. A bit of 1 lets it run. The receiver holds the frame in a shadow register. It hands the whole word to the outputs only on the serial clock edge that follows the last enable bit. A partly shifted frame therefore never reaches the clocks.

Each committed enable bit crosses into the domain of the generating clock through its own synchronizer chain. A per-output gate then applies the bit. The gate updates its internal enable only while its source clock is low. A frozen output therefore stops at a natural falling point, and a released output resumes at a natural rising point, so no shortened pulse ever appears. The free-running source clocks are treated as signals that change on edges of the generating clock.

Top module: `frz_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every enable defaults to 1, so each gated output equals its source clock until a frame is committed.
- R2: While the receiver is idle, a sampled serial data value of 1 is ignored. A frame starts only when a 0 is sampled on a rising serial clock edge.
- R3: The enable bits follow the start bit in a fixed order. The first bit after the start bit controls output index 0, and the k-th bit controls output index k-1, up to index NUM_OUT-1.
- R4: A committed enable bit of 0 holds its output at 0. A committed enable bit of 1 makes the output follow its source clock.
- R5: A new enable word has no effect at the outputs until the rising serial clock edge that follows the last enable bit.
- R6: If the data sampled on that commit edge is 0, it serves as the start bit of the next frame, and the next NUM_OUT bits form that frame. If it is 1, the receiver returns to idle.
- R7: A gated output rises only together with a rising edge of its source clock, and falls only together with a falling edge of its source clock, so no shortened pulse appears.
- R8: While an output is frozen, it stays at 0 for as long as its enable remains 0, through any number of source clock periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_clk | input | 1 | Serial clock. Data is sampled on its rising edge (at most 20 MHz). |
| ser_data | input | 1 | Serial data line: start bit, then the enable bits. |
| rst_n | input | 1 | Active-low reset, sampled synchronously in both clock domains. |
| gen_clk | input | 1 | Generating clock. The source clocks change on its rising edges. |
| src_clk | input | NUM_OUT | Free-running source clocks, one for each gated output. |
| gated_clk | output | NUM_OUT | Gated clocks. Each one is its source clock, or 0 while frozen. |

## Verification
The bench builds the block with NUM_OUT=12 and SYNC_STAGES=3. The deeper synchronizer exercises the generated chain beyond its minimum length, and it lengthens the time between a commit and its effect, which the settle window in the bench must cover. The twelve source clocks have half periods of one to four generating-clock cycles. Enable changes therefore land at every phase of the source clocks, whether high, low or at an edge, and this is what the no-shortened-pulse property depends on. The frames mix back-to-back chaining, idle runs of ones, a held-off commit edge, and walking-zero words that pin down the bit order.

// File: rtl/frz_pkg.sv
// Package: shared types for the serial freeze controller.
// Assumes nothing beyond IEEE 1800-2017 enums.
package frz_pkg;

    // Receiver states: waiting for a start bit, shifting enables, committing.
    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_SHIFT  = 2'd1,
        RX_COMMIT = 2'd2
    } rx_state_t;

endpackage

// File: rtl/frz_serial_rx.sv
// Module: frz_serial_rx
// Receives start-bit framed enable words on the serial link. It shifts
// NUM_OUT bits, with the first bit landing at index 0, and commits them to
// the enable register on the edge after the last bit. That edge also samples
// the next start bit.
// Assumes ser_data is stable around each rising ser_clk edge.
module frz_serial_rx
    import frz_pkg::*;
#(
    parameter int NUM_OUT = 12
) (
    input  logic               ser_clk,
    input  logic               rst_n,
    input  logic               ser_data,
    output logic [NUM_OUT-1:0] en_word
);

    localparam int CW = $clog2(NUM_OUT + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(NUM_OUT - 1);

    rx_state_t          state;
    logic [CW-1:0]      bit_cnt;
    logic [NUM_OUT-1:0] shadow;
    logic [NUM_OUT-1:0] en_q;

    // Framing state machine, shift register and enable commit.
    always_ff @(posedge ser_clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            bit_cnt <= '0;
            shadow  <= '0;
            en_q    <= '1;
        end else begin
            case (state)
                RX_IDLE: begin
                    bit_cnt <= '0;
                    if (!ser_data) state <= RX_SHIFT;
                end
                RX_SHIFT: begin
                    shadow <= {ser_data, shadow[NUM_OUT-1:1]};
                    if (bit_cnt == LAST_IDX) begin
                        state <= RX_COMMIT;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                RX_COMMIT: begin
                    en_q    <= shadow;
                    bit_cnt <= '0;
                    state   <= ser_data ? RX_IDLE : RX_SHIFT;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assign en_word = en_q;

    // R2: ones seen while idle keep the receiver idle.
    assert_idle_hold_R2: assert property (@(posedge ser_clk) disable iff (!rst_n)
        (state == RX_IDLE && ser_data) |=> (state == RX_IDLE));

    // R3: the bit counter never passes the last enable index.
    assert_cnt_range_R3: assert property (@(posedge ser_clk) disable iff (!rst_n)
        (state == RX_SHIFT) |-> (bit_cnt <= LAST_IDX));

    // R5: the commit edge transfers the shadow word.
    assert_commit_word_R5: assert property (@(posedge ser_clk) disable iff (!rst_n)
        (state == RX_COMMIT) |=> (en_q == $past(shadow)));

    // R5: enables change only after a commit state.
    assert_no_early_R5: assert property (@(posedge ser_clk) disable iff (!rst_n)
        !$stable(en_q) |-> ($past(state) == RX_COMMIT));

    // R6: a zero on the commit edge starts the next frame.
    assert_chain_R6: assert property (@(posedge ser_clk) disable iff (!rst_n)
        (state == RX_COMMIT && !ser_data) |=> (state == RX_SHIFT && bit_cnt == '0));

endmodule

// File: rtl/frz_sync.sv
// Module: frz_sync
// Carries each enable bit into the generating-clock domain through its own
// chain of STAGES flops. The bits are independent, so they need no coherency.
// Assumes STAGES >= 2. Reset loads 1 so that the outputs run.
module frz_sync #(
    parameter int NUM_OUT = 12,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OUT-1:0] d,
    output logic [NUM_OUT-1:0] q
);

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift one enable bit through its synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], d[i]};
        end

        assign q[i] = chain[STAGES-1];
    end

endmodule

// File: rtl/frz_gate.sv
// Module: frz_gate
// Glitch-free stop-low gate for one clock. The live enable is reloaded only
// while the source is low, so an edge of the output is always an edge of the
// source. Assumes src changes only on rising edges of clk.
module frz_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic en_sync,
    output logic gated
);

    logic live;

    // Take a new enable only during the low phase of the source clock.
    always_ff @(posedge clk) begin
        if (!rst_n)   live <= 1'b1;
        else if (!src) live <= en_sync;
    end

    assign gated = src & live;

    // R7: the output rises only with its source.
    assert_rise_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gated) |-> $rose(src));

    // R7: the output falls only with its source.
    assert_fall_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gated) |-> $fell(src));

    // R8: a synchronized zero seen in a low phase keeps the output low next cycle.
    assert_frozen_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!src && !en_sync) |=> !gated);

endmodule

// File: rtl/frz_ctrl.sv
// Module: frz_ctrl (top)
// Serial output freeze controller: the serial receiver, the per-bit
// synchronizers, and one glitch-free gate for each freezable clock.
// Assumes the source clocks change on rising edges of gen_clk, and rst_n is
// held low across several edges of both clocks.
module frz_ctrl #(
    parameter int NUM_OUT     = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic               ser_clk,
    input  logic               ser_data,
    input  logic               rst_n,
    input  logic               gen_clk,
    input  logic [NUM_OUT-1:0] src_clk,
    output logic [NUM_OUT-1:0] gated_clk
);

    logic [NUM_OUT-1:0] en_word;
    logic [NUM_OUT-1:0] en_sync;

    frz_serial_rx #(.NUM_OUT(NUM_OUT)) u_rx (
        .ser_clk  (ser_clk),
        .rst_n    (rst_n),
        .ser_data (ser_data),
        .en_word  (en_word)
    );

    frz_sync #(.NUM_OUT(NUM_OUT), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (gen_clk),
        .rst_n (rst_n),
        .d     (en_word),
        .q     (en_sync)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_gate
        frz_gate u_gate (
            .clk     (gen_clk),
            .rst_n   (rst_n),
            .src     (src_clk[i]),
            .en_sync (en_sync[i]),
            .gated   (gated_clk[i])
        );
    end

endmodule

// File: tb/tb_frz_ctrl.sv
// Bench for frz_ctrl: directed corner cases plus seeded random frames.
module tb_frz_ctrl;

    localparam int N = 12;

    logic          ser_clk = 1'b0;
    logic          ser_data = 1'b1;
    logic          rst_n = 1'b0;
    logic          gen_clk = 1'b0;
    logic [N-1:0]  src_clk = '0;
    logic [N-1:0]  gated_clk;

    int n_checks = 0;
    int n_fail   = 0;
    int edge_err = 0;
    bit done     = 1'b0;
    bit in_frame = 1'b0;
    logic [N-1:0] cur_en;

    frz_ctrl #(.NUM_OUT(N), .SYNC_STAGES(3)) dut (
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .rst_n     (rst_n),
        .gen_clk   (gen_clk),
        .src_clk   (src_clk),
        .gated_clk (gated_clk)
    );

    always #10 gen_clk = ~gen_clk;   // 50 MHz

    // Source clocks: output i has a half period of (i%4)+1 generating cycles.
    int hcnt [N];
    always_ff @(posedge gen_clk) begin
        for (int i = 0; i < N; i++) begin
            if (hcnt[i] >= (i % 4)) begin
                hcnt[i]    <= 0;
                src_clk[i] <= ~src_clk[i];
            end else begin
                hcnt[i] <= hcnt[i] + 1;
            end
        end
    end

    // R7 monitor: an edge on a gated output must coincide with the same edge on its source.
    logic [N-1:0] p_src = '0, p_gat = '0;
    always @(negedge gen_clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst_n && !p_gat[i] && gated_clk[i] && !(src_clk[i] && !p_src[i])) edge_err++;
            if (rst_n && p_gat[i] && !gated_clk[i] && !(!src_clk[i] && p_src[i])) edge_err++;
        end
        p_src = src_clk;
        p_gat = gated_clk;
    end

    function automatic logic [N-1:0] expect_out(input logic [N-1:0] src, input logic [N-1:0] en);
        return src & en;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic send_bit(input logic b);
        ser_data = b;
        #25 ser_clk = 1'b1;
        #25 ser_clk = 1'b0;
    endtask

    // Send the enable bits of a frame, first bit for index 0; no commit edge.
    task automatic send_body(input logic [N-1:0] w);
        if (!in_frame) send_bit(1'b0);
        for (int k = 0; k < N; k++) send_bit(w[k]);
    endtask

    task automatic send_frame(input logic [N-1:0] w, input bit chain);
        send_body(w);
        send_bit(chain ? 1'b0 : 1'b1);
        in_frame = chain;
    endtask

    // Let the enables settle, then compare every sample of a window.
    task automatic check_steady(input logic [N-1:0] en, input string tag);
        int bad = 0;
        logic [N-1:0] act = '0, exp_v = '0;
        repeat (30) @(negedge gen_clk);
        for (int c = 0; c < 24; c++) begin
            @(negedge gen_clk);
            if (gated_clk !== expect_out(src_clk, en)) begin
                if (bad == 0) begin act = gated_clk; exp_v = expect_out(src_clk, en); end
                bad++;
            end
        end
        n_checks++;
        if (bad != 0) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    initial begin
        #3000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [N-1:0] w;
        int sd;
        sd = $urandom(1234);
        cur_en = '1;

        // R1: reset state, checked during reset and after release.
        repeat (3) send_bit(1'b1);
        repeat (4) @(negedge gen_clk);
        n_checks++;
        if (gated_clk !== src_clk) begin
            n_fail++;
            $display("FAIL R1 in reset actual=%h expected=%h", gated_clk, src_clk);
        end
        #205 rst_n = 1'b1;
        check_steady('1, "R1 after reset");

        // R2: a run of ones while idle changes nothing.
        repeat (10) send_bit(1'b1);
        check_steady('1, "R2 idle ones");

        // R3 and R4: walking zero at the first, a middle and the last position.
        foreach (w[k]) begin end
        for (int k = 0; k < N; k += 5) begin
            w = '1; w[k] = 1'b0;
            send_frame(w, 1'b0);
            check_steady(w, "R3 walking zero");
        end
        w = '1; w[N-1] = 1'b0;
        send_frame(w, 1'b0);
        check_steady(w, "R3 last index");
        cur_en = w;

        // R8: all frozen stays low over many source periods.
        send_frame('0, 1'b0);
        check_steady('0, "R8 all frozen");
        cur_en = '0;

        // R5: the full body is held off until the commit edge.
        w = 12'hA5C;
        send_body(w);
        check_steady(cur_en, "R5 before commit edge");
        send_bit(1'b1);
        in_frame = 1'b0;
        check_steady(w, "R5 after commit edge");
        cur_en = w;

        // R6: back-to-back frames, the commit edge supplies the next start bit.
        send_frame(12'h3C3, 1'b1);
        check_steady(12'h3C3, "R6 first chained");
        send_frame(12'hC3C, 1'b0);
        check_steady(12'hC3C, "R6 second chained");
        cur_en = 12'hC3C;

        // Random frames with random chaining and idle runs (R4, R6, R2).
        for (int f = 0; f < 20; f++) begin
            bit ch;
            w  = N'($urandom());
            ch = $urandom_range(0, 1) == 1;
            send_frame(w, ch);
            check_steady(w, "R4 random frame");
            if (!in_frame) begin
                repeat ($urandom_range(0, 3)) send_bit(1'b1);
            end
        end
        if (in_frame) begin
            send_frame('1, 1'b0);
            check_steady('1, "R6 closing frame");
        end

        // R7: no output edge ever came apart from its source edge.
        n_checks++;
        if (edge_err != 0) begin
            n_fail++;
            $display("FAIL R7 misaligned edges actual=%0d expected=0", edge_err);
        end
        finish_run();
    end

endmodule